// File: doc/BRIEF.md
# Hash Message Word Expander

This block feeds the compression rounds of a 256-bit iterated hash. It takes one 512-bit message block, unpacks it into sixteen 32-bit words, and then hands out one pair of round words per advance strobe: the expanded word Wj and the derived word W'j = Wj ^ W[j+4]. It covers rounds 0 to 63 and then reports completion.

The later words, W16 to W67, are produced on the fly from a sixteen-word sliding window. Each word is built from five earlier words through a rotation-based mixing function. Because of this, the 68-word schedule is never stored. The round engine loads a block and reads (Wj, W'j) while `vld_o` is high. It raises `adv_i` once for each round it consumes.

Top module: `wexp_core`

## Requirements
- R1: While and after a synchronous active-high reset, `vld_o` and `done_o` are low and `rnd_o` is zero.
- R2: Byte i of the block is `blk_i[8i+7:8i]`. Word k is formed big-endian: byte 4k is bits 31:24, byte 4k+1 is bits 23:16, byte 4k+2 is bits 15:8 and byte 4k+3 is bits 7:0.
- R3: For rounds 0 to 15, `w_o` shows the loaded word of the same index.
- R4: For j from 16 to 67, Wj = P1(W[j-16] ^ W[j-9] ^ rotl(W[j-3],15)) ^ rotl(W[j-13],7) ^ W[j-6]. Here P1(x) = x ^ rotl(x,15) ^ rotl(x,23) and rotl is a 32-bit left rotation.
- R5: `wp_o` equals Wj ^ W[j+4] for the current round j. Round 63 therefore uses W67.
- R6: While `vld_o` is high, an `adv_i` pulse moves to the next round on the next cycle. Without `adv_i`, `w_o`, `wp_o` and `rnd_o` hold their values.
- R7: The 64th advance drops `vld_o` and raises `done_o` on the next cycle. `done_o` stays high until the next accepted load.
- R8: A load issued while `vld_o` is high is ignored: the round index and the output words are unchanged.
- R9: A load is accepted when the block is idle or done. On the next cycle `vld_o` is high, `rnd_o` is 0, `done_o` is low and `w_o` shows W0.
- R10: An `adv_i` pulse while `vld_o` is low changes neither `vld_o` nor `done_o`.
- R11: A reset in the middle of a block abandons it: the block returns to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Request to load a new message block |
| blk_i | input | 512 | Message block, byte i in bits 8i+7:8i |
| adv_i | input | 1 | Consume the current round pair |
| vld_o | output | 1 | Round pair on w_o/wp_o is valid |
| rnd_o | output | 6 | Index of the current round |
| w_o | output | 32 | Expanded word Wj |
| wp_o | output | 32 | Derived word Wj ^ W[j+4] |
| done_o | output | 1 | All 64 round pairs have been delivered |

## Verification
The bench walks several blocks through all 64 rounds and inserts stall gaps between advances. If the window shifted without an advance, or failed to hold, the round index and the words would drift from the reference schedule.

A byte-ramp block exposes a wrong byte order by showing a swapped W0. A block holding only the value 1 in W0 pins down W16 = 0x00808001, so a wrong tap or rotation amount gives a different value. The same value appears in W'12, which catches a wrong look-ahead distance.

The bench also issues a load while rounds are in progress, an advance after completion, and a reset partway through a block. A design that restarted on the load, left its done state, or kept running after reset is caught by the checks that follow each of these.

// File: rtl/wexp_pkg.sv
`timescale 1ns/1ps
package wexp_pkg;
   localparam int unsigned WEXP_WORD_W = 32;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } wexp_state_e;

   function automatic logic [WEXP_WORD_W-1:0] rotl(input logic [WEXP_WORD_W-1:0] x,
                                                 input int unsigned n);
      return (x << n) | (x >> (WEXP_WORD_W - n));
   endfunction

   function automatic logic [WEXP_WORD_W-1:0] perm1(input logic [WEXP_WORD_W-1:0] x);
      return x ^ rotl(x, 15) ^ rotl(x, 23);
   endfunction
endpackage

// File: rtl/wexp_unpack.sv
`timescale 1ns/1ps
module wexp_unpack #(
   parameter int unsigned NWORDS  = 16,
   parameter int unsigned WORD_W  = 32,
   parameter bit          BIG_END = 1'b1
) (
   input  logic [NWORDS*WORD_W-1:0]     blk_i,
   output logic [NWORDS-1:0][WORD_W-1:0] words_o
);
   localparam int unsigned NBYTES = WORD_W / 8;

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      if (BIG_END) begin : g_be
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            // lowest-addressed byte of the word lands in the top lane
            assign words_o[k][WORD_W-1-8*b -: 8] = blk_i[k*WORD_W + 8*b +: 8];
         end
      end else begin : g_le
         assign words_o[k] = blk_i[k*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/wexp_next.sv
`timescale 1ns/1ps
module wexp_next
   import wexp_pkg::*;
#(
   parameter int unsigned NWORDS = 16,
   parameter int unsigned WORD_W = 32
) (
   input  logic [NWORDS-1:0][WORD_W-1:0] win_i,
   output logic [WORD_W-1:0]             nxt_o
);
   // window slot 0 holds W[j]; the new word is W[j+NWORDS]
   localparam int unsigned TAP_16 = 0;
   localparam int unsigned TAP_13 = NWORDS - 13;
   localparam int unsigned TAP_9  = NWORDS - 9;
   localparam int unsigned TAP_6  = NWORDS - 6;
   localparam int unsigned TAP_3  = NWORDS - 3;

   logic [WORD_W-1:0] mix;

   always_comb begin
      mix   = win_i[TAP_16] ^ win_i[TAP_9] ^ rotl(win_i[TAP_3], 15);
      nxt_o = perm1(mix) ^ rotl(win_i[TAP_13], 7) ^ win_i[TAP_6];
   end
endmodule

// File: rtl/wexp_seq.sv
`timescale 1ns/1ps
module wexp_seq
   import wexp_pkg::*;
#(
   parameter int unsigned NROUNDS = 64,
   parameter int unsigned RND_W   = $clog2(NROUNDS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             adv_i,
   output logic             take_o,
   output logic             step_o,
   output logic             vld_o,
   output logic             done_o,
   output logic [RND_W-1:0] rnd_o
);
   localparam logic [RND_W-1:0] LAST = RND_W'(NROUNDS - 1);

   wexp_state_e      st;
   logic [RND_W-1:0] rnd;

   assign take_o = load_i && (st != ST_RUN);
   assign step_o = adv_i && (st == ST_RUN);

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= ST_IDLE;
         rnd <= '0;
      end else if (take_o) begin
         st  <= ST_RUN;
         rnd <= '0;
      end else if (step_o) begin
         if (rnd == LAST) st <= ST_DONE;
         else             rnd <= rnd + 1'b1;
      end
   end

   assign vld_o  = (st == ST_RUN);
   assign done_o = (st == ST_DONE);
   assign rnd_o  = rnd;
endmodule

// File: rtl/wexp_core.sv
`timescale 1ns/1ps
module wexp_core #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned NWORDS  = 16,
   parameter int unsigned NROUNDS = 64,
   parameter int unsigned PEEK    = 4,
   parameter bit          BIG_END = 1'b1,
   parameter int unsigned RND_W   = $clog2(NROUNDS)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load_i,
   input  logic [NWORDS*WORD_W-1:0] blk_i,
   input  logic                     adv_i,
   output logic                     vld_o,
   output logic [RND_W-1:0]         rnd_o,
   output logic [WORD_W-1:0]        w_o,
   output logic [WORD_W-1:0]        wp_o,
   output logic                     done_o
);
   if (WORD_W != wexp_pkg::WEXP_WORD_W) begin : g_bad_width
      $error("wexp_core: rotation amounts are defined for 32-bit words only");
   end
   if (NWORDS != 16) begin : g_bad_window
      $error("wexp_core: recurrence taps require a 16-word window");
   end
   if (PEEK == 0 || PEEK >= NWORDS) begin : g_bad_peek
      $error("wexp_core: PEEK must lie inside the window");
   end
   if (NROUNDS < 2 || (1 << RND_W) < NROUNDS) begin : g_bad_rounds
      $error("wexp_core: NROUNDS does not fit the round counter");
   end

   logic [NWORDS-1:0][WORD_W-1:0] unpacked;
   logic [NWORDS-1:0][WORD_W-1:0] win;
   logic [WORD_W-1:0]             nxt;
   logic                          take, step;

   wexp_unpack #(.NWORDS(NWORDS), .WORD_W(WORD_W), .BIG_END(BIG_END)) unpack_i (
      .blk_i   (blk_i),
      .words_o (unpacked)
   );

   wexp_next #(.NWORDS(NWORDS), .WORD_W(WORD_W)) next_i (
      .win_i (win),
      .nxt_o (nxt)
   );

   wexp_seq #(.NROUNDS(NROUNDS), .RND_W(RND_W)) seq_i (
      .clk    (clk),
      .rst    (rst),
      .load_i (load_i),
      .adv_i  (adv_i),
      .take_o (take),
      .step_o (step),
      .vld_o  (vld_o),
      .done_o (done_o),
      .rnd_o  (rnd_o)
   );

   for (genvar s = 0; s < NWORDS; s++) begin : g_slot
      logic [WORD_W-1:0] shift_in;
      if (s == NWORDS - 1) begin : g_tail
         assign shift_in = nxt;
      end else begin : g_body
         assign shift_in = win[s+1];
      end

      always_ff @(posedge clk) begin
         if (rst)       win[s] <= '0;
         else if (take) win[s] <= unpacked[s];
         else if (step) win[s] <= shift_in;
      end
   end

   assign w_o  = win[0];
   assign wp_o = win[0] ^ win[PEEK];
endmodule

// File: rtl/wexp_core_chk.sv
`timescale 1ns/1ps
module wexp_core_chk #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned NROUNDS = 64,
   parameter int unsigned RND_W   = $clog2(NROUNDS)
) (
   input logic              clk,
   input logic              rst,
   input logic              load_i,
   input logic              adv_i,
   input logic              vld_o,
   input logic              done_o,
   input logic [RND_W-1:0]  rnd_o,
   input logic [WORD_W-1:0] w_o,
   input logic [WORD_W-1:0] wp_o
);
   localparam logic [RND_W-1:0] LAST = RND_W'(NROUNDS - 1);

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!vld_o && !done_o && rnd_o == '0));

   // R9
   load_start_chk: assert property (@(posedge clk) disable iff (rst)
      (load_i && !vld_o) |=> (vld_o && !done_o && rnd_o == '0));

   // R8
   busy_load_chk: assert property (@(posedge clk) disable iff (rst)
      (load_i && vld_o && !adv_i) |=> (vld_o && $stable(rnd_o) && $stable(w_o) && $stable(wp_o)));

   // R6
   round_step_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_o && adv_i && rnd_o != LAST) |=> (vld_o && rnd_o == $past(rnd_o) + 1'b1));

   // R6
   round_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_o && !adv_i) |=> (vld_o && $stable(rnd_o) && $stable(w_o)));

   // R7
   finish_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_o && adv_i && rnd_o == LAST) |=> (!vld_o && done_o));

   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && !load_i) |=> done_o);

   // R10
   idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
      (!vld_o && !load_i && adv_i) |=> (!vld_o && done_o == $past(done_o)));

   // R7
   excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(vld_o && done_o));
endmodule

bind wexp_core wexp_core_chk #(.WORD_W(WORD_W), .NROUNDS(NROUNDS), .RND_W(RND_W)) chk_i (
   .clk    (clk),
   .rst    (rst),
   .load_i (load_i),
   .adv_i  (adv_i),
   .vld_o  (vld_o),
   .done_o (done_o),
   .rnd_o  (rnd_o),
   .w_o    (w_o),
   .wp_o   (wp_o)
);

// File: tb/wexp_core_tb.sv
`timescale 1ns/1ps
module wexp_core_tb_top;
   localparam int NT = 5;
   localparam logic [511:0] BLK_TAB [NT] = '{
      512'd0,
      {16{32'h6162_6380}},
      {8{64'h0123_4567_89ab_cdef}},
      {4{128'hfedc_ba98_7654_3210_0f1e_2d3c_4b5a_6978}},
      (512'h1 << 500) | 512'hdead_beef
   };
   localparam int GAP_TAB [NT] = '{0, 1, 3, 0, 2};

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_i = 1'b0;
   logic [511:0] blk_i = '0;
   logic         adv_i = 1'b0;
   logic         vld_o, done_o;
   logic [5:0]   rnd_o;
   logic [31:0]  w_o, wp_o;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] ref_w [68];

   always #2.5 clk = ~clk;

   wexp_core dut_i (
      .clk (clk), .rst (rst), .load_i (load_i), .blk_i (blk_i), .adv_i (adv_i),
      .vld_o (vld_o), .rnd_o (rnd_o), .w_o (w_o), .wp_o (wp_o), .done_o (done_o)
   );

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   task automatic build_ref(input logic [511:0] b);
      for (int k = 0; k < 16; k++)
         ref_w[k] = {b[32*k +: 8], b[32*k+8 +: 8], b[32*k+16 +: 8], b[32*k+24 +: 8]};
      for (int j = 16; j < 68; j++) begin
         logic [31:0] x;
         x = ref_w[j-16] ^ ref_w[j-9] ^ rl(ref_w[j-3], 15);
         ref_w[j] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(ref_w[j-13], 7) ^ ref_w[j-6];
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_load(input logic [511:0] b);
      load_i = 1'b1;
      blk_i  = b;
      step();
      load_i = 1'b0;
   endtask

   task automatic do_adv(input int n);
      for (int i = 0; i < n; i++) begin
         adv_i = 1'b1;
         step();
         adv_i = 1'b0;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      step(); step();
      // R1: reset state
      check("R1 vld", {31'd0, vld_o}, 32'd0);
      check("R1 done", {31'd0, done_o}, 32'd0);
      check("R1 rnd", {26'd0, rnd_o}, 32'd0);
      rst = 1'b0;
      step();

      // table walk: R3 R4 R5 R6 R7 R9
      for (int t = 0; t < NT; t++) begin
         build_ref(BLK_TAB[t]);
         do_load(BLK_TAB[t]);
         check("R9 vld after load", {31'd0, vld_o}, 32'd1);
         check("R9 done cleared", {31'd0, done_o}, 32'd0);
         for (int r = 0; r < 64; r++) begin
            for (int g = 0; g < GAP_TAB[t]; g++) step();
            check("R6 rnd", {26'd0, rnd_o}, r);
            check(r < 16 ? "R3 w" : "R4 w", w_o, ref_w[r]);
            check("R5 wp", wp_o, ref_w[r] ^ ref_w[r+4]);
            do_adv(1);
         end
         check("R7 vld low", {31'd0, vld_o}, 32'd0);
         check("R7 done high", {31'd0, done_o}, 32'd1);
         step(); step();
         check("R7 done held", {31'd0, done_o}, 32'd1);
      end

      // R2: byte ramp, byte i = i
      begin
         logic [511:0] ramp;
         for (int i = 0; i < 64; i++) ramp[8*i +: 8] = 8'(i);
         do_load(ramp);
         check("R2 W0", w_o, 32'h0001_0203);
         check("R2 W'0", wp_o, 32'h0001_0203 ^ 32'h1011_1213);
         do_adv(1);
         check("R2 W1", w_o, 32'h0405_0607);
         do_adv(63);
      end

      // R4 / R5: W0 = 1, all else zero -> W16 = 0x00808001
      do_load(512'h01 << 24);
      check("R3 W0 single", w_o, 32'h0000_0001);
      do_adv(12);
      check("R5 W'12 single", wp_o, 32'h0080_8001);
      do_adv(4);
      check("R4 W16 single", w_o, 32'h0080_8001);

      // R8: load while running is ignored
      load_i = 1'b1;
      blk_i  = {16{32'hffff_ffff}};
      step();
      load_i = 1'b0;
      check("R8 rnd unchanged", {26'd0, rnd_o}, 32'd16);
      check("R8 w unchanged", w_o, 32'h0080_8001);
      check("R8 vld", {31'd0, vld_o}, 32'd1);
      do_adv(48);
      check("R7 done single", {31'd0, done_o}, 32'd1);

      // R10: advance while not valid
      do_adv(3);
      check("R10 vld", {31'd0, vld_o}, 32'd0);
      check("R10 done", {31'd0, done_o}, 32'd1);

      // R9: load from done state restarts
      build_ref(BLK_TAB[2]);
      do_load(BLK_TAB[2]);
      check("R9 restart rnd", {26'd0, rnd_o}, 32'd0);
      check("R9 restart w", w_o, ref_w[0]);
      do_adv(20);
      check("R4 mid w", w_o, ref_w[20]);

      // R11: reset mid-block
      rst = 1'b1;
      step();
      rst = 1'b0;
      step();
      check("R11 vld", {31'd0, vld_o}, 32'd0);
      check("R11 done", {31'd0, done_o}, 32'd0);
      check("R11 rnd", {26'd0, rnd_o}, 32'd0);
      do_adv(2);
      check("R10 after reset", {31'd0, vld_o}, 32'd0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule